// File: doc/BRIEF.md
# Time-Dithered DAC Resolution Extender

This block sits in front of an 8-bit voltage DAC and gives it 1 to 4 extra bits of effective resolution. It takes a wide input code and splits it into two parts. The 8-bit base is the coarse level. The low remainder is a fraction of one DAC step. On every dither slot the block sends the DAC either the base or the base plus one count. The choice follows a repeating pattern in time, and the pattern's average equals the fraction. After the DAC's analog output is low-pass filtered, the result is a level between two adjacent codes. With the 4-bit setting, a converter whose step is 16 mV behaves close to a converter with a 1 mV step.

A two-bit resolution select chooses the number of extra bits N, from 1 to 4. The input code is read as a right-aligned value of 8+N significant bits. A slot enable input sets the dither rate: the pattern moves forward by one slot on each clock cycle where the enable is high. The pattern period is 2^N slots. The +1 slots are spread evenly across the period by first-order error accumulation. A new code or a new select is taken only at the start of a period, so the average over any period is never a mix of two settings.

Top module: `dither_dac_ext`

## Requirements
- R1: While reset is high, and after it, until the first slot: dac_code is 0.
- R2: dac_code changes only on a clock edge where slot_en is high. On all other edges it holds its value.
- R3: After each slot, dac_code is either the current base or the base plus one.
- R4: With res_sel = s, the number of extra bits is N = s+1. The base is bits [N+7:N] of code_in and the fraction is bits [N-1:0]. The bits of code_in above N+7 have no effect.
- R5: In every period of 2^N slots, exactly as many slots output base+1 as the fraction value.
- R6: Slot i of a period (i from 0) outputs base+1 exactly when floor((i+1)·f/2^N) > floor(i·f/2^N). So slot 0 always outputs the base, and the +1 slots are spread evenly.
- R7: When the base is 255, the output stays at 255 and never wraps to 0.
- R8: code_in and res_sel are sampled only on the first slot of a period. A change in the middle of a period has no effect until the next period starts.
- R9: The slot position wraps after 2^N slots of the N in force, so periods of different lengths follow each other with no gap.
- R10: A fraction of 0 gives a constant base output for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 12 | Wide code, right-aligned to 8+N bits |
| res_sel | input | 2 | Extra bits select, N = res_sel+1 |
| slot_en | input | 1 | Advances the dither pattern by one slot |
| dac_code | output | 8 | Code for the 8-bit DAC |

## Verification
dac_code is registered. The value for a slot is therefore visible on the clock edge that samples slot_en high, and the bench reads it at the falling edge that follows. After each slot the bench adds one idle cycle and checks that the value held. The bench tracks the slot position itself from reset onward. It always drives whole periods, which keeps it aligned with the period boundary, and it computes each expected code from the floor formula rather than from an accumulator. For the mid-period change, the new inputs are applied after the third slot. The remaining slots of that period are checked against the old setting, and the next period is checked against the new one.

// File: rtl/dither_pkg.sv
`timescale 1ns/1ps
package dither_pkg;
    localparam int DAC_W     = 8;
    localparam int EXTRA_MAX = 4;
    localparam int CODE_W    = DAC_W + EXTRA_MAX;
    localparam int SEL_W     = $clog2(EXTRA_MAX);

    typedef logic [DAC_W-1:0]     dac_t;
    typedef logic [EXTRA_MAX-1:0] frac_t;
    typedef logic [CODE_W-1:0]    code_t;
    typedef logic [SEL_W-1:0]     sel_t;

    typedef struct packed {
        dac_t  base;
        frac_t frac;
        sel_t  sel;
    } setting_t;

    // All-ones mask of N = sel+1 bits
    function automatic frac_t period_mask(input sel_t sel);
        logic [EXTRA_MAX:0] wide;
        wide = ((EXTRA_MAX+1)'(1) << (int'(sel) + 1)) - (EXTRA_MAX+1)'(1);
        return wide[EXTRA_MAX-1:0];
    endfunction

    function automatic setting_t split_code(input code_t c, input sel_t sel);
        setting_t s;
        code_t    m;
        m      = (code_t'(1) << (int'(sel) + 1)) - code_t'(1);
        s.base = dac_t'(c >> (int'(sel) + 1));
        s.frac = frac_t'(c & m);
        s.sel  = sel;
        return s;
    endfunction
endpackage

// File: rtl/dither_setting_hold.sv
`timescale 1ns/1ps
module dither_setting_hold
    import dither_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  code_t    code_in,
    input  sel_t     res_sel,
    input  logic     slot_en,
    input  logic     boundary,
    output setting_t active,
    output setting_t held
);
    setting_t fresh;

    always_comb begin
        fresh  = split_code(code_in, res_sel);
        active = boundary ? fresh : held;
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (slot_en && boundary)
            held <= fresh;
    end

    // R8: the held setting changes only at a period start
    a_r8_latch_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !(slot_en && boundary) |=> $stable(held));
endmodule

// File: rtl/dither_slot_timer.sv
`timescale 1ns/1ps
module dither_slot_timer
    import dither_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_en,
    input  frac_t active_mask,
    input  frac_t held_mask,
    output logic  boundary
);
    frac_t pos;

    assign boundary = (pos == '0);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (slot_en)
            pos <= (pos + frac_t'(1)) & active_mask;
    end

    // R9: slot position stays inside the period of the held setting
    a_r9_pos_in_period: assert property (@(posedge clk) disable iff (rst)
        (pos & ~held_mask) == '0);
endmodule

// File: rtl/dither_err_accum.sv
`timescale 1ns/1ps
module dither_err_accum
    import dither_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_en,
    input  logic  boundary,
    input  frac_t frac,
    input  frac_t mask,
    output logic  carry
);
    frac_t              acc;
    logic [EXTRA_MAX:0] sum;

    always_comb begin
        sum   = {1'b0, (boundary ? frac_t'(0) : acc)} + {1'b0, frac};
        carry = sum > {1'b0, mask};
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (slot_en)
            acc <= sum[EXTRA_MAX-1:0] & mask;
    end

    // R6: first slot of a period never carries
    a_r6_first_slot_base: assert property (@(posedge clk) disable iff (rst)
        boundary |-> !carry);
endmodule

// File: rtl/dither_dac_ext.sv
`timescale 1ns/1ps
module dither_dac_ext
    import dither_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CODE_W-1:0]    code_in,
    input  logic [SEL_W-1:0]     res_sel,
    input  logic                 slot_en,
    output logic [DAC_W-1:0]     dac_code
);
    setting_t active;
    setting_t held;
    logic     boundary;
    logic     carry;
    frac_t    active_mask;
    frac_t    held_mask;

    assign active_mask = period_mask(active.sel);
    assign held_mask   = period_mask(held.sel);

    dither_setting_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .code_in  (code_in),
        .res_sel  (res_sel),
        .slot_en  (slot_en),
        .boundary (boundary),
        .active   (active),
        .held     (held)
    );

    dither_slot_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .slot_en     (slot_en),
        .active_mask (active_mask),
        .held_mask   (held_mask),
        .boundary    (boundary)
    );

    dither_err_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .slot_en  (slot_en),
        .boundary (boundary),
        .frac     (active.frac),
        .mask     (active_mask),
        .carry    (carry)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dac_code <= '0;
        else if (slot_en)
            dac_code <= (carry && active.base != '1) ? active.base + dac_t'(1) : active.base;
    end

    // R2: output holds between slots
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> $stable(dac_code));

    // R3: output is base or base+1
    a_r3_adjacent_code: assert property (@(posedge clk) disable iff (rst)
        slot_en |=> (dac_code == $past(active.base)) ||
                    (dac_code == $past(active.base) + dac_t'(1)));

    // R7: no wrap at the top code
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (slot_en && active.base == '1) |=> dac_code == '1);
endmodule

// File: tb/dither_dac_ext_tb.sv
`timescale 1ns/1ps
module dither_dac_ext_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] code_in = '0;
    logic [1:0]  res_sel = '0;
    logic        slot_en = 1'b0;
    logic [7:0]  dac_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dither_dac_ext dut_i (
        .clk(clk), .rst(rst), .code_in(code_in), .res_sel(res_sel),
        .slot_en(slot_en), .dac_code(dac_code)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_slot(input int base, input int f, input int n, input int i);
        int up;
        up = (((i+1)*f) >> n) - ((i*f) >> n);
        if (base == 255) return 255;
        return base + up;
    endfunction

    // one slot, then an idle cycle; returns 1 if output was base+1
    task automatic do_slot(input int exp, input int base, input string req, output int up);
        int v;
        @(negedge clk); slot_en = 1'b1;
        @(negedge clk); slot_en = 1'b0;
        v = dac_code;
        check(v, exp, req);
        up = (v == base + 1) ? 1 : 0;
        @(negedge clk);
        check(dac_code, v, "R2 hold between slots");
    endtask

    task automatic run_period(input int c, input int sel, input string req);
        int n, base, f, ones, up;
        n = sel + 1;
        base = (c >> n) & 255;
        f = c & ((1 << n) - 1);
        @(negedge clk); code_in = 12'(c); res_sel = 2'(sel);
        ones = 0;
        for (int i = 0; i < (1 << n); i++) begin
            do_slot(exp_slot(base, f, n, i), base, req, up);
            ones += up;
        end
        if (base != 255) check(ones, f, "R5 ones per period");
    endtask

    task automatic t_reset;
        check(dac_code, 0, "R1 reset value");
    endtask

    task automatic t_basic;
        run_period(12'h5A7, 3, "R6 spread 12-bit");
        run_period(12'h0B5, 3, "R6 spread 12-bit odd");
    endtask

    task automatic t_modes;
        for (int s = 0; s < 4; s++) run_period(12'hABD, s, "R4 split per select");
        run_period(12'hF3B, 1, "R4 upper bits ignored");
    endtask

    task automatic t_zero_frac;
        run_period(12'h370, 3, "R10 zero fraction");
    endtask

    task automatic t_saturate;
        run_period(12'hFF9, 3, "R7 top code saturates");
        run_period(12'hFEF, 3, "R7 base 254 full fraction");
    endtask

    task automatic t_midchange;
        int up;
        // A: sel 2, N=3, code 0x123 -> base 0x24, f 3
        @(negedge clk); code_in = 12'h123; res_sel = 2'd2;
        for (int i = 0; i < 3; i++) do_slot(exp_slot(8'h24, 3, 3, i), 8'h24, "R8 before change", up);
        @(negedge clk); code_in = 12'h3F7; res_sel = 2'd1;
        for (int i = 3; i < 8; i++) do_slot(exp_slot(8'h24, 3, 3, i), 8'h24, "R8 ignore mid-period", up);
        // B: N=2, base (0x3F7>>2)&255 = 0xFD, f 3
        for (int i = 0; i < 4; i++) do_slot(exp_slot(8'hFD, 3, 2, i), 8'hFD, "R9 new period length", up);
        run_period(12'h3F7, 0, "R9 shortest period");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        check(dac_code, 0, "R1 value before first slot");
        t_basic();
        t_modes();
        t_zero_frac();
        t_saturate();
        t_midchange();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule